// File: doc/BRIEF.md
# Serial CRC-8 Validator

This block accumulates an 8-bit cyclic redundancy check over a stream of bits received from a single-wire serial bus. The generator is x^8 + x^5 + x^4 + 1, applied in reflected form with least significant bit first. The register starts from an all-zero seed. A caller clears the accumulator, feeds the protected data one bit at a time, and then feeds the received check byte in the same way. A zero residue after the check byte means the data arrived intact.

A second input path accepts a whole byte per cycle. It processes the byte least significant bit first and gives exactly the state that eight serial steps would give. The caller decides how many bytes form a frame, for example a 56-bit identifier plus its check byte, or a 9-byte block whose last byte carries the check. The zero flag is then read once the frame has been fed in.

Top module: `crc8_validator`

## Requirements
- R1: One serial step with `bit_vld_i` high computes fb = `bit_i` XOR `crc_o[0]`, shifts the register right by one, and XORs 8Ch into the result when fb is 1. This is the reflected form of x^8+x^5+x^4+1, and the result is visible on `crc_o` after the clock edge.
- R2: While `rst_n` is low the register holds the seed 00h, so `crc_o` = 00h and `zero_o` = 1.
- R3: `clr_i` high loads 00h at the next edge, whatever `bit_vld_i` and `byte_vld_i` are in that cycle.
- R4: With `clr_i`, `bit_vld_i` and `byte_vld_i` all low, `crc_o` keeps its value.
- R5: `byte_vld_i` high applies the eight bits of `byte_i` in the order bit 0 to bit 7. The result equals eight serial steps with those bits.
- R6: When `byte_vld_i` and `bit_vld_i` are both high (and `clr_i` low), the byte is applied first and the serial bit second, giving nine steps in one cycle.
- R7: `zero_o` is 1 exactly when `crc_o` is 00h. Feeding a value equal to the current `crc_o` (as a byte, or bit 0 first serially) leaves a zero residue. A stream with one corrupted bit leaves a nonzero residue.
- R8: A 56-bit identifier followed by its check byte, or a 9-byte block whose byte 8 is the check of bytes 0 to 7, fed least significant bit first from bit 0 of the first byte, ends with `zero_o` = 1.
- R9: `bit_i` has no effect while `bit_vld_i` is low, and `byte_i` has no effect while `byte_vld_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Restart the accumulation from the seed |
| bit_vld_i | input | 1 | `bit_i` holds a bit to accumulate |
| bit_i | input | 1 | Serial data bit |
| byte_vld_i | input | 1 | `byte_i` holds a byte to accumulate |
| byte_i | input | 8 | Byte data, bit 0 is applied first |
| crc_o | output | 8 | Current remainder |
| zero_o | output | 1 | Remainder is zero (frame accepted) |

## Verification
A wrong feedback tap or a wrong bit order in either path shows on `crc_o` at the very edge after the step that went wrong. The bench compares the register to a reference every cycle, so such an error is caught at once rather than only in the final residue. A corrupted state survives until the next clear, which makes the end-of-frame `zero_o` wrong as well. A priority error between clear, byte and bit shows in the single cycle where those inputs coincide, so that case is driven directly.

// File: rtl/crc8v_pkg.sv
package crc8v_pkg;
   // default remainder width and reflected generator (x^8+x^5+x^4+1)
   localparam int unsigned  CRC8V_W         = 8;
   localparam logic [7:0]   CRC8V_POLY_REFL = 8'h8C;
   localparam logic [7:0]   CRC8V_SEED      = 8'h00;

   // register update selector
   typedef enum logic [1:0] {
      UPD_HOLD    = 2'd0,
      UPD_CLEAR   = 2'd1,
      UPD_ADVANCE = 2'd2
   } crc8v_upd_e;
endpackage

// File: rtl/crc8v_step.sv
module crc8v_step #(
   parameter int unsigned     W    = 8,
   parameter logic [W-1:0]    POLY = 8'h8C
) (
   input  logic [W-1:0] crc_i,
   input  logic         d_i,
   output logic [W-1:0] crc_o
);
   logic fb;

   always_comb begin
      fb    = d_i ^ crc_i[0];
      crc_o = (crc_i >> 1) ^ (fb ? POLY : '0);
   end
endmodule

// File: rtl/crc8v_lane.sv
module crc8v_lane #(
   parameter int unsigned     W    = 8,
   parameter int unsigned     N    = 8,
   parameter logic [W-1:0]    POLY = 8'h8C
) (
   input  logic [W-1:0] crc_i,
   input  logic [N-1:0] data_i,
   output logic [W-1:0] crc_o
);
   logic [W-1:0] chain [0:N];

   assign chain[0] = crc_i;

   for (genvar gi = 0; gi < N; gi++) begin : g_bit
      crc8v_step #(.W(W), .POLY(POLY)) u_step (
         .crc_i (chain[gi]),
         .d_i   (data_i[gi]),
         .crc_o (chain[gi+1])
      );
   end

   assign crc_o = chain[N];
endmodule

// File: rtl/crc8v_state.sv
module crc8v_state
   import crc8v_pkg::*;
#(
   parameter int unsigned     W    = 8,
   parameter logic [W-1:0]    SEED = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  crc8v_upd_e   upd_i,
   input  logic [W-1:0] nxt_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= SEED;
      end else begin
         case (upd_i)
            UPD_CLEAR:   q_o <= SEED;
            UPD_ADVANCE: q_o <= nxt_i;
            default:     q_o <= q_o;
         endcase
      end
   end
endmodule

// File: rtl/crc8_validator.sv
module crc8_validator
   import crc8v_pkg::*;
#(
   parameter int unsigned        CRC_W         = CRC8V_W,
   parameter int unsigned        BYTE_W        = 8,
   parameter logic [CRC_W-1:0]   POLY          = CRC8V_POLY_REFL,
   parameter logic [CRC_W-1:0]   SEED          = CRC8V_SEED,
   parameter bit                 HAS_BYTE_PATH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              bit_vld_i,
   input  logic              bit_i,
   input  logic              byte_vld_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic [CRC_W-1:0]  crc_o,
   output logic              zero_o
);
   localparam int unsigned STEPS_MAX = BYTE_W + 1;

   // elaboration-time parameter checks
   if (CRC_W < 2) begin : g_bad_width
      $error("crc8_validator: CRC_W must be at least 2");
   end
   if (BYTE_W < 1) begin : g_bad_byte
      $error("crc8_validator: BYTE_W must be at least 1");
   end
   if (POLY[CRC_W-1] != 1'b1) begin : g_bad_poly
      $error("crc8_validator: reflected POLY needs its top bit set");
   end
   if (STEPS_MAX < 2) begin : g_bad_steps
      $error("crc8_validator: step count underflow");
   end

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_after_byte;
   logic [CRC_W-1:0] crc_step_bit;
   logic [CRC_W-1:0] crc_nxt;
   crc8v_upd_e       upd;

   // byte path variant chosen by parameter
   if (HAS_BYTE_PATH) begin : g_byte_path
      logic [CRC_W-1:0] lane_out;
      crc8v_lane #(.W(CRC_W), .N(BYTE_W), .POLY(POLY)) u_lane (
         .crc_i  (crc_q),
         .data_i (byte_i),
         .crc_o  (lane_out)
      );
      assign crc_after_byte = byte_vld_i ? lane_out : crc_q;
   end else begin : g_no_byte_path
      assign crc_after_byte = crc_q;
   end

   // serial bit is applied after the byte
   crc8v_step #(.W(CRC_W), .POLY(POLY)) u_bit_step (
      .crc_i (crc_after_byte),
      .d_i   (bit_i),
      .crc_o (crc_step_bit)
   );

   always_comb begin
      crc_nxt = bit_vld_i ? crc_step_bit : crc_after_byte;
      if (clr_i)                                      upd = UPD_CLEAR;
      else if (bit_vld_i || (byte_vld_i && HAS_BYTE_PATH)) upd = UPD_ADVANCE;
      else                                            upd = UPD_HOLD;
   end

   crc8v_state #(.W(CRC_W), .SEED(SEED)) u_state (
      .clk   (clk),
      .rst_n (rst_n),
      .upd_i (upd),
      .nxt_i (crc_nxt),
      .q_o   (crc_q)
   );

   assign crc_o  = crc_q;
   assign zero_o = (crc_q == '0);
endmodule

// File: rtl/crc8v_chk.sv
module crc8v_chk #(
   parameter int unsigned        CRC_W         = 8,
   parameter int unsigned        BYTE_W        = 8,
   parameter logic [CRC_W-1:0]   SEED          = '0,
   parameter bit                 HAS_BYTE_PATH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              bit_vld_i,
   input  logic              bit_i,
   input  logic              byte_vld_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic [CRC_W-1:0]  crc_o,
   input  logic              zero_o
);
   AST_CLEAR_SEED: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (crc_o == SEED)); // R3

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !bit_vld_i && !byte_vld_i) |=> $stable(crc_o)); // R4

   AST_NO_FEEDBACK_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && bit_vld_i && !byte_vld_i && (bit_i == crc_o[0]))
      |=> (crc_o == ($past(crc_o) >> 1))); // R1

   if (HAS_BYTE_PATH && (BYTE_W == CRC_W)) begin : g_self
      AST_SELF_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_i && !bit_vld_i && byte_vld_i && (byte_i == crc_o)) |=> zero_o); // R7
   end
endmodule

bind crc8_validator crc8v_chk #(
   .CRC_W(CRC_W), .BYTE_W(BYTE_W), .SEED(SEED), .HAS_BYTE_PATH(HAS_BYTE_PATH)
) u_chk (.*);

// File: tb/crc8_validator_bench.sv
module crc8_validator_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr_i = 1'b0;
   logic       bit_vld_i = 1'b0;
   logic       bit_i = 1'b0;
   logic       byte_vld_i = 1'b0;
   logic [7:0] byte_i = 8'h00;
   logic [7:0] crc_o;
   logic       zero_o;

   int checks = 0;
   int failures = 0;
   logic [7:0] exp_crc = 8'h00;
   bit done = 1'b0;

   always #5 clk = ~clk;

   crc8_validator u_crc8_validator (
      .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .bit_vld_i(bit_vld_i),
      .bit_i(bit_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
      .crc_o(crc_o), .zero_o(zero_o)
   );

   function automatic logic [7:0] m_step(input logic [7:0] c, input logic b);
      logic fb;
      fb = b ^ c[0];
      return (c >> 1) ^ (fb ? 8'h8C : 8'h00);
   endfunction

   function automatic logic [7:0] m_byte(input logic [7:0] c, input logic [7:0] d);
      logic [7:0] r;
      r = c;
      for (int i = 0; i < 8; i++) r = m_step(r, d[i]);
      return r;
   endfunction

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, got, exp);
      end
   endtask

   // drive one cycle, update the reference, compare after the edge
   task automatic cyc(input string tag, input logic c, input logic bv, input logic b,
                      input logic yv, input logic [7:0] y);
      @(negedge clk);
      clr_i = c; bit_vld_i = bv; bit_i = b; byte_vld_i = yv; byte_i = y;
      @(posedge clk);
      #1;
      if (c) exp_crc = 8'h00;
      else begin
         if (yv) exp_crc = m_byte(exp_crc, y);
         if (bv) exp_crc = m_step(exp_crc, b);
      end
      check({tag, " crc"}, crc_o, exp_crc);
      check({tag, " zero"}, {7'd0, zero_o}, {7'd0, exp_crc == 8'h00});
   endtask

   task automatic feed_serial(input string tag, input logic [7:0] d);
      for (int i = 0; i < 8; i++) cyc(tag, 1'b0, 1'b1, d[i], 1'b0, 8'h00);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] blk [0:8];
      logic [7:0] acc;
      void'($urandom(32'd1207));
      repeat (3) @(posedge clk);
      #1;
      check("R2 reset crc", crc_o, 8'h00);
      check("R2 reset zero", {7'd0, zero_o}, 8'h01);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: 01h fed serially gives 5Eh
      feed_serial("R1 serial 01h", 8'h01);
      check("R1 value 01h", crc_o, 8'h5E);
      // R7: appending the remainder gives zero
      cyc("R7 self byte", 1'b0, 1'b0, 1'b0, 1'b1, 8'h5E);
      check("R7 residue zero", {7'd0, zero_o}, 8'h01);
      // R5: byte path matches serial result
      cyc("R5 byte 01h", 1'b0, 1'b0, 1'b0, 1'b1, 8'h01);
      check("R5 value 01h", crc_o, 8'h5E);
      // R9/R4: toggling data with valids low changes nothing
      cyc("R9 ignore a", 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF);
      cyc("R9 ignore b", 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C);
      cyc("R4 idle", 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
      check("R4 held", crc_o, 8'h5E);
      // R6: byte then bit in one cycle
      cyc("R6 both", 1'b0, 1'b1, 1'b1, 1'b1, 8'hA5);
      check("R6 order", crc_o, m_step(m_byte(8'h5E, 8'hA5), 1'b1));
      // R3: clear beats both valids
      cyc("R3 clear prio", 1'b1, 1'b1, 1'b1, 1'b1, 8'hC3);
      check("R3 cleared", crc_o, 8'h00);

      // R8: 9-byte block, serial
      acc = 8'h00;
      for (int k = 0; k < 8; k++) begin
         blk[k] = 8'($urandom);
         acc = m_byte(acc, blk[k]);
      end
      blk[8] = acc;
      for (int k = 0; k < 9; k++) feed_serial("R8 block", blk[k]);
      check("R8 block accepted", {7'd0, zero_o}, 8'h01);
      // R7: one corrupted bit must be rejected
      cyc("R7 clear", 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
      for (int k = 0; k < 9; k++)
         cyc("R7 corrupt", 1'b0, 1'b0, 1'b0, 1'b1, (k == 3) ? (blk[k] ^ 8'h10) : blk[k]);
      check("R7 corrupt rejected", {7'd0, zero_o}, 8'h00);

      // R8: 56-bit identifier with family byte 10h
      cyc("R8 clear", 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
      acc = m_byte(8'h00, 8'h10);
      feed_serial("R8 id", 8'h10);
      for (int k = 0; k < 6; k++) begin
         logic [7:0] v;
         v = 8'($urandom);
         acc = m_byte(acc, v);
         feed_serial("R8 id", v);
      end
      feed_serial("R8 id crc", acc);
      check("R8 id accepted", {7'd0, zero_o}, 8'h01);

      // random mix: R1 R3 R4 R5 R6 R9 checked every cycle
      for (int n = 0; n < 600; n++) begin
         logic [3:0] r;
         r = 4'($urandom);
         cyc("R1/R3/R5/R6/R9 random", r == 4'd0, r[1], 1'($urandom), r[2],
             8'($urandom));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule